// File: doc/BRIEF.md
# Triggered DAC Channel Control

This block holds the control state of one converter channel and moves a 12-bit sample from a holding register to the output register that feeds the analog converter. The moment of transfer depends on the channel's mode. Untriggered, the output follows a holding-register write one clock later. Triggered by software, it follows a one-shot strobe bit one clock later. Triggered by one of fifteen external event lines, it follows the selected line's rising edge three clocks later.

Software reaches the block through a plain word-wide port with four locations: control, holding data, software strobe, and status. In DMA mode every transfer raises a request that stays up until it is acknowledged. A transfer that arrives while the previous request is still pending sets an underrun flag. An interrupt is raised when that flag is set and its enable bit is on. The calibration-enable bit is locked while the channel is enabled.

Top module: `dac_chan_ctrl`

## Requirements
- R1: After reset the control word reads 0, `dac_out` is 0, and `dma_req` and `udr_irq` are low.
- R2: The control word (address 0) reads back what was written, at these bit positions: 0 enable, 1 trigger enable, 5:2 trigger select, 7:6 wave mode, 11:8 mask/amplitude, 12 DMA enable, 13 underrun interrupt enable, 14 calibration enable.
- R3: With the channel enabled and the trigger disabled, a write to the holding register (address 1) appears on `dac_out` one clock after the write edge, and not at the write edge.
- R4: With the trigger enabled and trigger select 0, holding writes do not reach `dac_out`. Writing 1 to bit 0 of address 2 transfers the holding value one clock after the write edge. The strobe bit clears itself, and address 2 reads 0.
- R5: With the trigger enabled and trigger select k (1 to 15), a rising edge on `ext_trig[k-1]` transfers the holding value three clocks after the edge at which the high level is first sampled. A level held high gives one transfer only, and the lines that are not selected have no effect.
- R6: While the enable bit is 0, neither trigger events nor holding writes change `dac_out`.
- R7: A write to the control word changes the calibration-enable bit only if the stored enable bit is 0 before that write. The other fields of the same write still update.
- R8: With DMA enable set, each triggered transfer raises `dma_req` in the same clock as the output update. `dma_ack` clears it. Status (address 3) bit 1 mirrors `dma_req`.
- R9: A triggered transfer in DMA mode while `dma_req` is high and not being acknowledged sets the underrun flag, which is status bit 0. Writing 1 to that bit clears it. `udr_irq` is high exactly when the flag and the underrun interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 2 | Location: 0 control, 1 holding, 2 strobe, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ext_trig | input | 15 | External event lines; bit k-1 is line k |
| dma_ack | input | 1 | Acknowledge for the pending DMA request |
| dac_out | output | 12 | Output register value driven to the converter |
| dma_req | output | 1 | DMA request |
| udr_irq | output | 1 | Underrun interrupt |

## Verification
A wrong transfer pipeline appears on `dac_out` as a value arriving one or more cycles early or late. The scoreboard catches it at the exact cycle where the value was due. A stale edge-detect register shows up as a missing transfer or a repeated one within a few cycles of the stimulus. A broken calibration lock or a corrupted control field appears at the next read of address 0. A mistake in the DMA state shows on `dma_req`, `udr_irq` and status within one cycle of the trigger or acknowledge that should have changed it.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    localparam int DATA_W    = 12;
    localparam int BUS_W     = 32;
    localparam int TSEL_W    = 4;
    localparam int WAVE_W    = 2;
    localparam int MAMP_W    = 4;
    localparam int NUM_EXT   = 15;
    localparam int EXT_DELAY = 3;

    typedef enum logic [1:0] {
        A_CTRL   = 2'd0,
        A_HOLD   = 2'd1,
        A_STROBE = 2'd2,
        A_STAT   = 2'd3
    } loc_e;

    // LSB first in bit order: en is bit 0, cen is the top bit
    typedef struct packed {
        logic              cen;
        logic              udrie;
        logic              dmaen;
        logic [MAMP_W-1:0] mamp;
        logic [WAVE_W-1:0] wave;
        logic [TSEL_W-1:0] tsel;
        logic              ten;
        logic              en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // New control value from a write; calibration bit locked while enabled
    function automatic ctrl_t ctrl_merge(input ctrl_t cur, input logic [BUS_W-1:0] wd);
        ctrl_t nxt;
        nxt = ctrl_t'(wd[CTRL_W-1:0]);
        if (cur.en) nxt.cen = cur.cen;
        return nxt;
    endfunction
endpackage

// File: rtl/dacc_regs.sv
module dacc_regs
    import dacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wdata,
    output ctrl_t            ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_merge(ctrl_q, wdata);
    end

    assign ctrl = ctrl_q;

    // R1: control state is cleared by reset
    a_r1_ctrl_reset: assert property (@(posedge clk) rst |=> ctrl_q == '0);
    // R7: calibration bit cannot move while the channel is enabled
    a_r7_cen_locked: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.en |=> $stable(ctrl_q.cen));
endmodule

// File: rtl/dacc_trig.sv
module dacc_trig
    import dacc_pkg::*;
#(
    parameter int N_EXT = NUM_EXT,
    parameter int DELAY = EXT_DELAY
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             strobe_wr,
    input  logic [N_EXT-1:0] ext_trig,
    output logic             trig_fire
);
    logic [N_EXT-1:0] prev_q;
    logic [N_EXT-1:0] rise_vec;
    logic             sel_rise;
    logic             sw_q;
    logic             ext_armed;
    logic             ext_out;

    assign rise_vec  = ext_trig & ~prev_q;
    assign ext_armed = ctrl.en && ctrl.ten && (ctrl.tsel != '0);

    always_comb begin
        sel_rise = 1'b0;
        for (int k = 1; k <= N_EXT; k++) begin
            if (ctrl.tsel == k[TSEL_W-1:0]) sel_rise = rise_vec[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            sw_q   <= 1'b0;
        end else begin
            prev_q <= ext_trig;
            sw_q   <= strobe_wr;   // one-shot, clears itself next cycle
        end
    end

    generate
        if (DELAY > 1) begin : g_pipe
            logic [DELAY-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[DELAY-2:0], sel_rise && ext_armed};
            end
            assign ext_out = pipe_q[DELAY-1];
        end else begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= sel_rise && ext_armed;
            end
            assign ext_out = stage_q;
        end
    endgenerate

    assign trig_fire = ctrl.en && ctrl.ten &&
                       ((ctrl.tsel == '0) ? sw_q : ext_out);

    // R4: software strobe lasts a single cycle unless rewritten
    a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        (sw_q && !strobe_wr) |=> !sw_q);
endmodule

// File: rtl/dacc_xfer.sv
module dacc_xfer
    import dacc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic          hold_wr,
    input  logic [DW-1:0] hold_din,
    input  logic          trig_fire,
    input  logic          dma_ack,
    input  logic          udr_clr,
    output logic [DW-1:0] hold_q,
    output logic [DW-1:0] dout,
    output logic          dma_req,
    output logic          udr
);
    logic load_pend_q;
    logic xfer;
    logic dma_evt;

    assign xfer    = ctrl.en && (ctrl.ten ? trig_fire : load_pend_q);
    assign dma_evt = trig_fire && ctrl.dmaen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            load_pend_q <= 1'b0;
            dout        <= '0;
        end else begin
            if (hold_wr) hold_q <= hold_din;
            load_pend_q <= hold_wr && !ctrl.ten;
            if (xfer) dout <= hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_req <= 1'b0;
            udr     <= 1'b0;
        end else begin
            if (dma_evt) begin
                dma_req <= 1'b1;
                if (dma_req && !dma_ack) udr <= 1'b1;
                else if (udr_clr)        udr <= 1'b0;
            end else begin
                if (dma_ack) dma_req <= 1'b0;
                if (udr_clr) udr     <= 1'b0;
            end
        end
    end

    // R6: a disabled channel keeps its output
    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> $stable(dout));
    // R8: acknowledge without a new event drops the request
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (dma_req && dma_ack && !dma_evt) |=> !dma_req);
    // R9: event on an unacknowledged request flags underrun
    a_r9_underrun_set: assert property (@(posedge clk) disable iff (rst)
        (dma_evt && dma_req && !dma_ack) |=> udr);
endmodule

// File: rtl/dac_chan_ctrl.sv
module dac_chan_ctrl
    import dacc_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int N_EXT = NUM_EXT,
    parameter int DELAY = EXT_DELAY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [N_EXT-1:0] ext_trig,
    input  logic             dma_ack,
    output logic [DW-1:0]    dac_out,
    output logic             dma_req,
    output logic             udr_irq
);
    loc_e          loc;
    ctrl_t         ctrl;
    logic          trig_fire;
    logic [DW-1:0] hold_q;
    logic          udr;
    logic          wr_ctrl, wr_hold, wr_strobe, wr_stat;

    assign loc       = loc_e'(addr);
    assign wr_ctrl   = wr_en && (loc == A_CTRL);
    assign wr_hold   = wr_en && (loc == A_HOLD);
    assign wr_strobe = wr_en && (loc == A_STROBE) && wdata[0];
    assign wr_stat   = wr_en && (loc == A_STAT) && wdata[0];

    dacc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (wdata),
        .ctrl    (ctrl)
    );

    dacc_trig #(.N_EXT(N_EXT), .DELAY(DELAY)) u_trig (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .strobe_wr (wr_strobe),
        .ext_trig  (ext_trig),
        .trig_fire (trig_fire)
    );

    dacc_xfer #(.DW(DW)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .hold_wr   (wr_hold),
        .hold_din  (wdata[DW-1:0]),
        .trig_fire (trig_fire),
        .dma_ack   (dma_ack),
        .udr_clr   (wr_stat),
        .hold_q    (hold_q),
        .dout      (dac_out),
        .dma_req   (dma_req),
        .udr       (udr)
    );

    assign udr_irq = udr && ctrl.udrie;

    always_comb begin
        rdata = '0;
        case (loc)
            A_CTRL:   rdata[CTRL_W-1:0] = ctrl;
            A_HOLD:   rdata[DW-1:0]     = hold_q;
            A_STROBE: rdata             = '0;
            A_STAT:   rdata[1:0]        = {dma_req, udr};
            default:  rdata             = '0;
        endcase
    end

    // R1: outputs idle right after reset
    a_r1_out_reset: assert property (@(posedge clk)
        rst |=> (dac_out == '0) && !dma_req);
    // R3: untriggered write lands one cycle after its edge
    a_r3_untrig_load: assert property (@(posedge clk) disable iff (rst)
        (wr_hold && ctrl.en && !ctrl.ten) |=> ##1 (dac_out == $past(wdata[DW-1:0], 2)));
    // R9: interrupt only with its enable
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        udr_irq |-> ctrl.udrie);
endmodule

// File: tb/dac_chan_ctrl_tb.sv
module dac_chan_ctrl_tb;
    import dacc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [14:0] ext_trig = '0;
    logic        dma_ack = 1'b0;
    logic [11:0] dac_out;
    logic        dma_req;
    logic        udr_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int          due_q[$];
    logic [11:0] val_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    dac_chan_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_trig(ext_trig), .dma_ack(dma_ack),
        .dac_out(dac_out), .dma_req(dma_req), .udr_irq(udr_irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_out(input int due, input logic [11:0] v, input string tag);
        due_q.push_back(due);
        val_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                if (due_q[0] < cyc) chk({tag_q[0], " missed slot"}, cyc, due_q[0]);
                else                chk(tag_q[0], dac_out, val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        idle(4);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, r);  chk("R1 ctrl", r, 0);
        chk("R1 dac_out", dac_out, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 udr_irq", udr_irq, 0);

        // R2 field positions
        wr(A_CTRL, 32'h6BA6);
        rd(A_CTRL, r);  chk("R2 readback", r, 32'h6BA6);

        // R7 calibration lock
        wr(A_CTRL, 32'h0001);  rd(A_CTRL, r);  chk("R7 clear while off", r, 32'h0001);
        wr(A_CTRL, 32'h4001);  rd(A_CTRL, r);  chk("R7 set while on", r, 32'h0001);
        wr(A_CTRL, 32'h4000);  rd(A_CTRL, r);  chk("R7 disable same write", r, 32'h0000);
        wr(A_CTRL, 32'h4000);  rd(A_CTRL, r);  chk("R7 set while off", r, 32'h4000);
        wr(A_CTRL, 32'h0000);

        // R3 untriggered loads
        wr(A_CTRL, 32'h0001);
        wr(A_HOLD, 32'hABC);
        chk("R3 not at write edge", dac_out, 0);
        expect_out(cyc + 1, 12'hABC, "R3 load");
        idle(1);
        wr(A_HOLD, 32'h123);
        expect_out(cyc + 1, 12'h123, "R3 load");
        idle(2);

        // R4 software trigger
        wr(A_CTRL, 32'h0003);
        wr(A_HOLD, 32'h555);
        rd(A_HOLD, r);  chk("R4 holding readback", r, 32'h555);
        idle(3);
        chk("R4 no load without strobe", dac_out, 12'h123);
        wr(A_STROBE, 32'h1);
        expect_out(cyc + 1, 12'h555, "R4 strobe");
        idle(1);
        rd(A_STROBE, r);  chk("R4 strobe reads 0", r, 0);
        idle(2);

        // R5 external trigger on line 4
        wr(A_CTRL, 32'h0013);
        wr(A_HOLD, 32'h777);
        ext_trig[3] = 1'b1;
        expect_out(cyc + 4, 12'h777, "R5 ext edge");
        idle(3);
        chk("R5 not before third cycle", dac_out, 12'h555);
        idle(2);
        wr(A_HOLD, 32'h888);
        idle(6);
        chk("R5 held level single", dac_out, 12'h777);
        ext_trig[6] = 1'b1;
        idle(6);
        chk("R5 unselected line", dac_out, 12'h777);
        ext_trig = '0;
        idle(2);
        ext_trig[3] = 1'b1;
        expect_out(cyc + 4, 12'h888, "R5 second edge");
        idle(6);
        ext_trig = '0;

        // R6 disabled channel
        wr(A_CTRL, 32'h0012);
        wr(A_HOLD, 32'h999);
        idle(1);
        ext_trig[3] = 1'b1;
        idle(6);
        chk("R6 ext ignored", dac_out, 12'h888);
        ext_trig = '0;
        wr(A_CTRL, 32'h0000);
        wr(A_HOLD, 32'h9AA);
        idle(3);
        chk("R6 write ignored", dac_out, 12'h888);

        // R8 DMA request and acknowledge
        wr(A_CTRL, 32'h1003);
        wr(A_HOLD, 32'h100);
        chk("R8 idle request", dma_req, 0);
        wr(A_STROBE, 32'h1);
        expect_out(cyc + 1, 12'h100, "R8 dma transfer");
        idle(1);
        chk("R8 request raised", dma_req, 1);
        rd(A_STAT, r);  chk("R8 status mirror", r, 32'h2);
        dma_ack = 1'b1;
        idle(1);
        dma_ack = 1'b0;
        chk("R8 ack clears", dma_req, 0);

        // R9 underrun and interrupt gating
        wr(A_STROBE, 32'h1);
        wr(A_STROBE, 32'h1);
        idle(1);
        rd(A_STAT, r);  chk("R9 underrun flag", r, 32'h3);
        chk("R9 irq gated off", udr_irq, 0);
        wr(A_CTRL, 32'h3003);
        chk("R9 irq on", udr_irq, 1);
        wr(A_STAT, 32'h1);
        chk("R9 irq after clear", udr_irq, 0);
        rd(A_STAT, r);  chk("R9 flag cleared", r, 32'h2);
        dma_ack = 1'b1;
        idle(1);
        dma_ack = 1'b0;
        rd(A_STAT, r);  chk("R9 status idle", r, 0);

        idle(4);
        chk("scoreboard drained", due_q.size(), 0);
        finish_run();
    end
endmodule